// File: doc/BRIEF.md
# Legacy Memory-Map Attribute Decoder

This block decides, for every CPU memory cycle, whether the cycle is served by main DRAM or handed to the PCI bus. It also reports whether the cycle may be cached. Below 1 MB the map is fixed in some places and programmable in others:

- The conventional-memory area always goes to DRAM.
- The video window always goes to PCI.
- Thirteen segments can each be enabled for reads, for writes and for caching: twelve 16 KB expansion and BIOS-extension segments, and one 64 KB system BIOS segment.

A segment that is not enabled for a cycle's direction is not remapped. That cycle passes to PCI instead. Above 1 MB, a programmable top-of-DRAM boundary splits DRAM from PCI memory space. The boot flash window at the top of the 4 GB space therefore always reaches PCI.

The attributes are loaded through a byte-wide configuration port that has combinational read-back. Each decision is registered and appears one clock after the cycle strobe. A sticky error flag records any change to a cache-enable bit made while the external L2 cache is enabled.

Top module: `legacy_mem_router`

## Requirements
- R1: The outputs `to_dram`, `to_pci` and `cacheable` and the flag `dec_valid` appear exactly one clock after a cycle presented with `cyc_valid` high. While `dec_valid` is high, exactly one of `to_dram`/`to_pci` is high. While `dec_valid` is low, all three outputs are low.
- R2: Addresses 0x00000–0x9FFFF go to DRAM and are cacheable, whatever the attribute settings and the direction.
- R3: Addresses 0xA0000–0xBFFFF go to PCI and are never cacheable.
- R4: Each attribute nibble holds read-enable in bit 0, write-enable in bit 1 and cache-enable in bit 2. Bit 3 is reserved and reads as 0. Offset 0x59 holds the 0xF0000–0xFFFFF segment in bits 6:4, and its low nibble reads as 0. Offset 0x5A+k (k = 0..5) holds segment 0xC0000+k·32 KB in bits 2:0 and segment 0xC4000+k·32 KB in bits 6:4. Written values read back from the same offset.
- R5: In an attribute segment, a read is sent to DRAM when read-enable is set and to PCI otherwise. A write is sent to DRAM when write-enable is set and to PCI otherwise.
- R6: `cacheable` is high only for a cycle routed to DRAM. In an attribute segment it also requires that segment's cache-enable bit.
- R7: After reset, all attribute bits are 0, so every attribute segment goes to PCI. Top-of-DRAM reads 1, the error flag is 0, and `dec_valid` is 0.
- R8: Top-of-DRAM is an 8-bit register at offset 0x57, in units of 1 MB. At or above 1 MB, an address whose bits 31:20 are below this value goes to DRAM and is cacheable. Any other address goes to PCI and is not cacheable, and this includes 0xFFF80000–0xFFFFFFFF.
- R9: A configuration write that changes any cache-enable bit while `l2_enable` is high still takes effect, and it sets `ce_err`. The flag stays set until a write to offset 0x58 with bit 0 = 1 clears it. Offset 0x58 reads the flag in bit 0.
- R10: Writes to any other offset are ignored. Reads from any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Memory cycle strobe |
| cyc_addr | input | 32 | Cycle byte address |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| l2_enable | input | 1 | External L2 cache is enabled |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| dec_valid | output | 1 | Decision valid, one clock after `cyc_valid` |
| to_dram | output | 1 | Cycle claimed by DRAM |
| to_pci | output | 1 | Cycle forwarded to PCI |
| cacheable | output | 1 | Cycle may be cached |
| ce_err | output | 1 | Sticky flag for a cache-enable change while L2 is on |

## Verification
The R8 assertion assumes that any address of 256 MB or more lies above every possible top-of-DRAM value, since the 8-bit register cannot exceed 255. The R9 assertion assumes that the flag falls only on an explicit clear write. It also assumes that configuration writes and cycle strobes are sampled on the same clock edge as the decision. The stimulus drives every input on the falling edge and holds each cycle strobe for a single clock. It changes the attributes only between cycles, so each registered decision depends on settled register contents.

// File: rtl/legacy_mem_router.sv
module legacy_mem_router #(
  parameter logic [7:0] TOM_OFS  = 8'h57,
  parameter logic [7:0] ERR_OFS  = 8'h58,
  parameter logic [7:0] ATTR_OFS = 8'h59,
  parameter int         TOM_W    = 8,
  parameter int         NSEG     = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_valid,
  input  logic [31:0] cyc_addr,
  input  logic        cyc_write,
  input  logic        l2_enable,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic        dec_valid,
  output logic        to_dram,
  output logic        to_pci,
  output logic        cacheable,
  output logic        ce_err
);

  localparam int BIOS_SEG = NSEG - 1;
  localparam int NREG     = (BIOS_SEG / 2) + 1;

  logic [NSEG-1:0][2:0] attr_q;
  logic [NSEG-1:0]      ce_chg;
  logic [TOM_W-1:0]     tom_q;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam logic [7:0] OFS = (s == BIOS_SEG) ? ATTR_OFS : ATTR_OFS + 8'(1 + s / 2);
    localparam bit         HI  = (s == BIOS_SEG) ? 1'b1 : ((s % 2) == 1);
    logic       hit;
    logic [2:0] nib;
    logic [2:0] a_q;
    assign hit = cfg_we && (cfg_addr == OFS);
    assign nib = HI ? cfg_wdata[6:4] : cfg_wdata[2:0];
    always_ff @(posedge clk) begin
      if (!rst_n)   a_q <= 3'b000;
      else if (hit) a_q <= nib;
    end
    assign attr_q[s] = a_q;
    assign ce_chg[s] = hit && (nib[2] != a_q[2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              tom_q <= TOM_W'(1);
    else if (cfg_we && cfg_addr == TOM_OFS)  tom_q <= cfg_wdata[TOM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                              ce_err <= 1'b0;
    else if (l2_enable && |ce_chg)                           ce_err <= 1'b1;
    else if (cfg_we && cfg_addr == ERR_OFS && cfg_wdata[0])  ce_err <= 1'b0;
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_addr == TOM_OFS)  cfg_rdata = 8'(tom_q);
    if (cfg_addr == ERR_OFS)  cfg_rdata = {7'b0, ce_err};
    if (cfg_addr == ATTR_OFS) cfg_rdata = {1'b0, attr_q[BIOS_SEG], 4'h0};
    for (int r = 1; r < NREG; r++)
      if (cfg_addr == ATTR_OFS + 8'(r))
        cfg_rdata = {1'b0, attr_q[2*r-1], 1'b0, attr_q[2*r-2]};
  end

  logic       below_1m;
  logic [5:0] blk;
  logic [3:0] seg_idx;
  logic [2:0] seg_attr;
  logic       seg_en;
  logic       d_dram, d_pci, d_cache;

  assign below_1m = (cyc_addr[31:20] == 12'h000);
  assign blk      = cyc_addr[19:14];
  assign seg_idx  = (blk[5:2] == 4'hF) ? 4'(BIOS_SEG) : 4'(blk - 6'h30);
  assign seg_attr = attr_q[seg_idx];
  assign seg_en   = cyc_write ? seg_attr[1] : seg_attr[0];

  always_comb begin
    d_dram  = 1'b0;
    d_pci   = 1'b0;
    d_cache = 1'b0;
    if (below_1m) begin
      if (cyc_addr[19:16] < 4'hA) begin
        d_dram  = 1'b1;
        d_cache = 1'b1;
      end else if (cyc_addr[19:18] != 2'b11) begin
        d_pci = 1'b1;
      end else begin
        d_dram  = seg_en;
        d_pci   = !seg_en;
        d_cache = seg_en && seg_attr[2];
      end
    end else if (cyc_addr[31:20] < 12'(tom_q)) begin
      d_dram  = 1'b1;
      d_cache = 1'b1;
    end else begin
      d_pci = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      to_dram   <= 1'b0;
      to_pci    <= 1'b0;
      cacheable <= 1'b0;
    end else begin
      dec_valid <= cyc_valid;
      to_dram   <= cyc_valid && d_dram;
      to_pci    <= cyc_valid && d_pci;
      cacheable <= cyc_valid && d_cache;
    end
  end

endmodule

// File: rtl/legacy_mem_router_chk.sv
module legacy_mem_router_chk #(
  parameter logic [7:0] ERR_OFS = 8'h58
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_valid,
  input logic [31:0] cyc_addr,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic        dec_valid,
  input logic        to_dram,
  input logic        to_pci,
  input logic        cacheable,
  input logic        ce_err
);

  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (to_dram ^ to_pci));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !(to_dram || to_pci || cacheable));

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> dec_valid);

  a_r2_dos_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_addr < 32'h000A_0000) |=> (to_dram && cacheable));

  a_r3_video_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_addr >= 32'h000A_0000 && cyc_addr < 32'h000C_0000)
      |=> (to_pci && !cacheable));

  a_r6_cache_dram: assert property (@(posedge clk) disable iff (!rst_n)
    cacheable |-> to_dram);

  a_r8_high_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_addr >= 32'h1000_0000) |=> (to_pci && !cacheable));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_err && !(cfg_we && cfg_addr == ERR_OFS && cfg_wdata[0])) |=> ce_err);

endmodule

bind legacy_mem_router legacy_mem_router_chk #(.ERR_OFS(ERR_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .dec_valid(dec_valid), .to_dram(to_dram), .to_pci(to_pci),
  .cacheable(cacheable), .ce_err(ce_err)
);

// File: tb/test_legacy_mem_router.sv
module test_legacy_mem_router;

  localparam time CYC = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        cyc_write = 1'b0;
  logic        l2_enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        dec_valid, to_dram, to_pci, cacheable, ce_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CYC/2) clk = ~clk;

  legacy_mem_router i_legacy_mem_router (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_write(cyc_write), .l2_enable(l2_enable), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dec_valid(dec_valid), .to_dram(to_dram), .to_pci(to_pci),
    .cacheable(cacheable), .ce_err(ce_err)
  );

  // {addr, write, dram, pci, cache}
  localparam int NV = 20;
  localparam logic [35:0] VEC [NV] = '{
    {32'h0000_0000, 1'b0, 3'b101},  // R2
    {32'h0009_FFFF, 1'b1, 3'b101},  // R2
    {32'h000A_0000, 1'b0, 3'b010},  // R3
    {32'h000B_FFFF, 1'b1, 3'b010},  // R3
    {32'h000C_0000, 1'b0, 3'b101},  // R5 R6 rw+ce
    {32'h000C_3FFF, 1'b1, 3'b101},  // R5
    {32'h000C_4000, 1'b0, 3'b100},  // R5 R6 read-only, no ce
    {32'h000C_4000, 1'b1, 3'b010},  // R5
    {32'h000D_0000, 1'b0, 3'b010},  // R5 write-only
    {32'h000D_0000, 1'b1, 3'b100},  // R5
    {32'h000E_4000, 1'b0, 3'b101},  // R4 R5
    {32'h000E_0000, 1'b0, 3'b010},  // R5 disabled
    {32'h000E_C000, 1'b1, 3'b100},  // R4 R6
    {32'h000F_0000, 1'b0, 3'b101},  // R4 R5 bios read
    {32'h000F_FFFF, 1'b1, 3'b010},  // R5 bios write
    {32'h0010_0000, 1'b0, 3'b101},  // R8
    {32'h003F_FFFF, 1'b1, 3'b101},  // R8
    {32'h0040_0000, 1'b0, 3'b010},  // R8 boundary
    {32'hFFFF_FFF0, 1'b0, 3'b010},  // R8 reset vector
    {32'hFFF8_0000, 1'b1, 3'b010}   // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic cycle(input string tag, input logic [31:0] a, input logic w, input logic [2:0] exp);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_addr = a; cyc_write = w;
    @(negedge clk);
    cyc_valid = 1'b0;
    check(tag, {28'b0, dec_valid, to_dram, to_pci, cacheable}, {28'b0, 1'b1, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 idle outputs", {28'b0, dec_valid, to_dram, to_pci, cacheable}, 32'h0);
    check("R7 ce_err", 32'(ce_err), 32'h0);
    cfg_read("R7 tom reset", 8'h57, 8'h01);
    cfg_read("R7 attr reset", 8'h5A, 8'h00);
    cycle("R7 segment to pci", 32'h000C_0000, 1'b0, 3'b010);
    cycle("R7 bios to pci", 32'h000F_0000, 1'b0, 3'b010);

    // R4 layout and reserved bits
    cfg_write(8'h59, 8'hFF);
    cfg_read("R4 bios reg reserved", 8'h59, 8'h70);
    cfg_write(8'h59, 8'h50);
    cfg_write(8'h5A, 8'h1F);
    cfg_read("R4 reserved bit3", 8'h5A, 8'h17);
    cfg_write(8'h5C, 8'h02);
    cfg_write(8'h5E, 8'h70);
    cfg_write(8'h5F, 8'h30);
    cfg_write(8'h57, 8'h04);
    cfg_read("R4 readback 5F", 8'h5F, 8'h30);
    cfg_read("R8 tom readback", 8'h57, 8'h04);
    check("R9 no err with l2 off", 32'(ce_err), 32'h0);

    for (int i = 0; i < NV; i++)
      cycle($sformatf("R5/R6 decode vector %0d", i), VEC[i][35:4], VEC[i][3], VEC[i][2:0]);

    // R1 idle cycle
    @(negedge clk);
    check("R1 idle after cycle", {28'b0, dec_valid, to_dram, to_pci, cacheable}, 32'h0);

    // R10 unmapped offsets
    cfg_write(8'h60, 8'hA5);
    cfg_read("R10 unmapped read", 8'h60, 8'h00);
    cfg_read("R10 unmapped 56", 8'h56, 8'h00);
    cycle("R10 map unchanged", 32'h000C_4000, 1'b0, 3'b100);

    // R9 cache-enable change with L2 on
    l2_enable = 1'b1;
    cfg_write(8'h5A, 8'h17);
    check("R9 same ce no err", 32'(ce_err), 32'h0);
    cfg_write(8'h5A, 8'h13);
    check("R9 err set", 32'(ce_err), 32'h1);
    cfg_read("R9 err readback", 8'h58, 8'h01);
    cycle("R9 write took effect", 32'h000C_0000, 1'b0, 3'b100);
    cfg_write(8'h58, 8'h00);
    check("R9 err held", 32'(ce_err), 32'h1);
    cfg_write(8'h58, 8'h01);
    check("R9 err cleared", 32'(ce_err), 32'h0);
    l2_enable = 1'b0;

    // R8 raising top of DRAM
    cfg_write(8'h57, 8'hFF);
    cycle("R8 tom 255 below", 32'h0FEF_FFFF, 1'b0, 3'b101);
    cycle("R8 tom 255 edge", 32'h0FF0_0000, 1'b1, 3'b010);

    // R7 reset again clears programmed state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_read("R7 tom after reset", 8'h57, 8'h01);
    cfg_read("R7 attr after reset", 8'h5E, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule